// File: doc/BRIEF.md
# GPIO Expander Register Decoder

This block sits behind a serial front end that has already shifted in and latched a 16-bit frame. On each valid frame it decodes a command byte and a data byte into a small register map that controls ten open-drain I/O ports. Each port owns one 8-bit control register. A port is pulled low only while its register holds 0x00. Any other value releases the pin, so the port can act as a logic-high open-drain output or as an input.

Besides the per-port registers, the map provides several other addresses. Four broadcast addresses copy one data byte into a fixed group of port registers in a single frame. Two status addresses return the live pin levels and ignore writes. One address holds a scratch byte, and one no-op address lets a daisy-chained device be skipped. A read frame produces a 16-bit answer for the front end to shift out during the next frame. The upper byte echoes the command and the lower byte carries the addressed value.

Top module: `gpx_regmap`

## Requirements
- R1: After reset every port register holds 0x01, so `pull_low` is all zero. The scratch byte is 0x00 and `rdata` is 0x0000.
- R2: A frame with bit 15 = 0 is a write. Bits 14..8 are the address and bits 7..0 are the data. A write to address 0x00..0x09 stores the data into the register of port 0..9. Writing 0x00 sets that port's `pull_low` bit from the next cycle on.
- R3: Any port register value other than 0x00 releases its pin (`pull_low` bit 0). This includes 0x01, 0x02 and 0xFF.
- R4: Broadcast writes store the data byte in several port registers in the same cycle. 0x0A writes ports 0..3, 0x0B writes ports 4..7, 0x0C writes ports 8..9 and 0x0D writes all ten ports.
- R5: A read of 0x0E returns pin levels 7..0 in data bits 7..0. A read of 0x0F returns pin 9 in bit 1 and pin 8 in bit 0, with bits 7..2 at zero.
- R6: Writes to 0x0E, 0x0F, the no-op address 0x20 and any unmapped address change no register.
- R7: Address 0x10 is a scratch byte that can be written and read back. Writing it never changes any port.
- R8: A frame with bit 15 = 1 is a read and changes no register. The clock edge that accepts it loads `rdata` with the command byte in bits 15..8 and the addressed value in bits 7..0. A read of a port register returns the register value.
- R9: The no-op address, the broadcast addresses and unmapped addresses read as 0x00 in the lower byte. A write frame loads `rdata` with 0x0000.
- R10: While `frame_valid` is low, no register and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: `frame` holds a new latched frame |
| frame | input | 16 | Command byte (bits 15..8) and data byte (bits 7..0) |
| pin_level | input | 10 | Sampled logic level of each port pin |
| pull_low | output | 10 | Per-port enable for the open-drain pull-down |
| rdata | output | 16 | Answer word for the front end to shift out |

## Verification
The bench targets the edges of the address decode. Broadcast groups must cover exactly their ports: a wrong mask would release or pull an extra pin. Writes to the status, no-op and unmapped addresses must be dropped: a decoder that aliased them onto port registers would move a pin. The bench sends a read frame whose data byte is 0x01, which would release a pulled port if reads were allowed to write. It also checks the packing of pins 8 and 9 in the second status byte, and it checks that nonzero values other than 0x01 still release a pin, which a design comparing against 0x01 would get wrong.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int NPORT = 10;
  localparam int RW    = 8;
  localparam int FW    = 16;
  localparam int AW    = 7;

  localparam logic [AW-1:0] A_GRP_LO  = 7'h0A;
  localparam logic [AW-1:0] A_GRP_MID = 7'h0B;
  localparam logic [AW-1:0] A_GRP_HI  = 7'h0C;
  localparam logic [AW-1:0] A_GRP_ALL = 7'h0D;
  localparam logic [AW-1:0] A_PIN_LO  = 7'h0E;
  localparam logic [AW-1:0] A_PIN_HI  = 7'h0F;
  localparam logic [AW-1:0] A_SCRATCH = 7'h10;
  localparam logic [AW-1:0] A_NOP     = 7'h20;

  localparam logic [RW-1:0] PORT_RST  = 8'h01;
  localparam logic [RW-1:0] SCR_RST   = 8'h00;

  typedef logic [NPORT-1:0][RW-1:0] port_regs_t;

  // Which port registers an address writes (single or broadcast)
  function automatic logic [NPORT-1:0] wr_mask(input logic [AW-1:0] a);
    logic [NPORT-1:0] m;
    m = '0;
    if (int'(a) < NPORT) m[int'(a)] = 1'b1;
    else begin
      case (a)
        A_GRP_LO:  m = 10'h00F;
        A_GRP_MID: m = 10'h0F0;
        A_GRP_HI:  m = 10'h300;
        A_GRP_ALL: m = '1;
        default:   m = '0;
      endcase
    end
    return m;
  endfunction

  // Value returned in the low byte of a read answer
  function automatic logic [RW-1:0] rd_value(input logic [AW-1:0] a,
                                             input port_regs_t regs,
                                             input logic [RW-1:0] scr,
                                             input logic [NPORT-1:0] pins);
    logic [RW-1:0] v;
    v = '0;
    if (int'(a) < NPORT) v = regs[int'(a)];
    else begin
      case (a)
        A_PIN_LO:  v = pins[7:0];
        A_PIN_HI:  v = {6'b0, pins[9:8]};
        A_SCRATCH: v = scr;
        default:   v = '0;
      endcase
    end
    return v;
  endfunction

  function automatic logic drives_low(input logic [RW-1:0] r);
    return r == '0;
  endfunction
endpackage

// File: rtl/gpx_cmd_decode.sv
module gpx_cmd_decode
  import gpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_valid,
  input  logic [FW-1:0]        frame,
  output logic                 rd_evt,
  output logic                 wr_evt,
  output logic [AW-1:0]        addr,
  output logic [RW-1:0]        wdata,
  output logic [RW-1:0]        cmd,
  output logic [NPORT-1:0]     port_wr,
  output logic                 scr_wr
);
  logic is_read;

  assign is_read = frame[FW-1];
  assign cmd     = frame[FW-1:RW];
  assign addr    = frame[FW-2:RW];
  assign wdata   = frame[RW-1:0];
  assign rd_evt  = frame_valid & is_read;
  assign wr_evt  = frame_valid & ~is_read;
  assign port_wr = wr_evt ? wr_mask(addr) : '0;
  assign scr_wr  = wr_evt && (addr == A_SCRATCH);

  // R8: a read frame never produces a write strobe
  a_r8_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |-> (port_wr == '0) && !scr_wr);

  // R6: status, no-op addresses write nothing
  a_r6_ro_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (addr == A_PIN_LO || addr == A_PIN_HI || addr == A_NOP))
      |-> (port_wr == '0) && !scr_wr);

  // R10: no strobe without a valid frame
  a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> (port_wr == '0) && !scr_wr && !rd_evt);
endmodule

// File: rtl/gpx_port_bank.sv
module gpx_port_bank
  import gpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORT-1:0]     port_wr,
  input  logic [RW-1:0]        wdata,
  output port_regs_t           port_q,
  output logic [NPORT-1:0]     pull_low
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          port_q[i] <= PORT_RST;
      else if (port_wr[i]) port_q[i] <= wdata;
    end
    assign pull_low[i] = drives_low(port_q[i]);

    // R2: writing 0x00 pulls the port low next cycle
    a_r2_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr[i] && wdata == '0) |=> pull_low[i]);

    // R3: any nonzero value releases the port
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr[i] && wdata != '0) |=> !pull_low[i]);

    // R6: without a strobe the register holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !port_wr[i] |=> $stable(port_q[i]));
  end
endmodule

// File: rtl/gpx_readback.sv
module gpx_readback
  import gpx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_evt,
  input  logic                 wr_evt,
  input  logic [RW-1:0]        cmd,
  input  logic [AW-1:0]        addr,
  input  port_regs_t           port_q,
  input  logic [RW-1:0]        scr_q,
  input  logic [NPORT-1:0]     pins,
  output logic [FW-1:0]        rdata
);
  logic [RW-1:0] sel_val;

  assign sel_val = rd_value(addr, port_q, scr_q, pins);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_evt) rdata <= {cmd, sel_val};
    else if (wr_evt) rdata <= '0;
  end

  // R8: the answer echoes the command byte
  a_r8_echo: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> rdata[FW-1:RW] == $past(cmd));

  // R9: a write frame clears the answer
  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> rdata == '0);

  // R5: upper status bits are zero
  a_r5_hi_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && addr == A_PIN_HI) |=> rdata[RW-1:2] == '0);
endmodule

// File: rtl/gpx_regmap.sv
module gpx_regmap
  import gpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic [15:0]      frame,
  input  logic [9:0]       pin_level,
  output logic [9:0]       pull_low,
  output logic [15:0]      rdata
);
  logic               rd_evt;
  logic               wr_evt;
  logic [AW-1:0]      addr;
  logic [RW-1:0]      wdata;
  logic [RW-1:0]      cmd;
  logic [NPORT-1:0]   port_wr;
  logic               scr_wr;
  port_regs_t         port_q;
  logic [RW-1:0]      scr_q;

  gpx_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame(frame),
    .rd_evt(rd_evt), .wr_evt(wr_evt), .addr(addr), .wdata(wdata),
    .cmd(cmd), .port_wr(port_wr), .scr_wr(scr_wr)
  );

  gpx_port_bank u_bank (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .wdata(wdata),
    .port_q(port_q), .pull_low(pull_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      scr_q <= SCR_RST;
    else if (scr_wr) scr_q <= wdata;
  end

  gpx_readback u_rb (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .cmd(cmd), .addr(addr), .port_q(port_q), .scr_q(scr_q),
    .pins(pin_level), .rdata(rdata)
  );

  // R1: outputs leave reset released and cleared
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pull_low == '0) && (rdata == '0) && (scr_q == SCR_RST));

  // R7: scratch writes store the byte and leave ports alone
  a_r7_scratch_store: assert property (@(posedge clk) disable iff (!rst_n)
    scr_wr |=> (scr_q == $past(wdata)) && $stable(pull_low));

  // R10: an idle cycle changes nothing visible
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> $stable(pull_low) && $stable(rdata) && $stable(scr_q));
endmodule

// File: tb/gpx_regmap_test.sv
`timescale 1ns/1ps
module gpx_regmap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [15:0] frame = '0;
  logic [9:0]  pin_level = '0;
  logic [9:0]  pull_low;
  logic [15:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpx_regmap uut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame(frame),
    .pin_level(pin_level), .pull_low(pull_low), .rdata(rdata)
  );

  // vector: {req[3:0], frame[15:0], pins[9:0], exp_pull[9:0], exp_rdata[15:0]}
  localparam int NV = 23;
  localparam logic [55:0] VEC [NV] = '{
    {4'd2,  16'h0000, 10'h000, 10'h001, 16'h0000},  // P0 low
    {4'd2,  16'h0300, 10'h000, 10'h009, 16'h0000},  // P3 low
    {4'd8,  16'h8000, 10'h000, 10'h009, 16'h8000},  // read P0
    {4'd8,  16'h8100, 10'h000, 10'h009, 16'h8101},  // read P1 reset value
    {4'd4,  16'h0B00, 10'h000, 10'h0F9, 16'h0000},  // group P4..P7
    {4'd4,  16'h0C00, 10'h000, 10'h3F9, 16'h0000},  // group P8..P9
    {4'd4,  16'h0A01, 10'h000, 10'h3F0, 16'h0000},  // group P0..P3 release
    {4'd3,  16'h0502, 10'h000, 10'h3D0, 16'h0000},  // 0x02 releases P5
    {4'd8,  16'h8500, 10'h000, 10'h3D0, 16'h8502},  // read P5
    {4'd7,  16'h10A5, 10'h000, 10'h3D0, 16'h0000},  // scratch write
    {4'd7,  16'h9000, 10'h000, 10'h3D0, 16'h90A5},  // scratch read
    {4'd6,  16'h0E00, 10'h000, 10'h3D0, 16'h0000},  // write status ignored
    {4'd6,  16'h0F00, 10'h000, 10'h3D0, 16'h0000},  // write status ignored
    {4'd6,  16'h2000, 10'h000, 10'h3D0, 16'h0000},  // no-op write
    {4'd6,  16'h1100, 10'h000, 10'h3D0, 16'h0000},  // unmapped write
    {4'd5,  16'h8E00, 10'h2C3, 10'h3D0, 16'h8EC3},  // pins 7..0
    {4'd5,  16'h8F00, 10'h2C3, 10'h3D0, 16'h8F02},  // pins 9..8
    {4'd9,  16'hA000, 10'h2C3, 10'h3D0, 16'hA000},  // no-op read
    {4'd9,  16'h8A00, 10'h000, 10'h3D0, 16'h8A00},  // broadcast reads zero
    {4'd3,  16'h0DFF, 10'h000, 10'h000, 16'h0000},  // 0xFF releases all
    {4'd8,  16'h8900, 10'h000, 10'h000, 16'h89FF},  // read P9
    {4'd4,  16'h0D00, 10'h000, 10'h3FF, 16'h0000},  // all low
    {4'd8,  16'h8401, 10'h000, 10'h3FF, 16'h8400}   // read with data: no write
  };

  function automatic string req_name(input logic [3:0] k);
    case (k)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] f, input logic [9:0] p);
    @(negedge clk);
    frame = f; pin_level = p; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pull_low in reset", {6'b0, pull_low}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pull_low after reset", {6'b0, pull_low}, 16'h0000);
    check("R1", "rdata after reset", rdata, 16'h0000);
    send(16'h9000, 10'h000);
    check("R1", "scratch reset value", rdata, 16'h9000);
    send(16'h8700, 10'h000);
    check("R1", "port reg reset value", rdata, 16'h8701);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][51:36], VEC[i][35:26]);
      check(req_name(VEC[i][55:52]), $sformatf("vec %0d pull_low", i),
            {6'b0, pull_low}, {6'b0, VEC[i][25:16]});
      check(req_name(VEC[i][55:52]), $sformatf("vec %0d rdata", i),
            rdata, VEC[i][15:0]);
    end

    // R10: idle cycles with a frame that would write if accepted
    @(negedge clk);
    frame = 16'h0D01; pin_level = 10'h3FF;
    repeat (3) @(negedge clk);
    check("R10", "idle pull_low", {6'b0, pull_low}, 16'h03FF);
    check("R10", "idle rdata", rdata, 16'h8400);

    // R9: unmapped read gives zero low byte
    send(16'h9100, 10'h3FF);
    check("R9", "unmapped read", rdata, 16'h9100);
    // R5: all pins high
    send(16'h8F00, 10'h3FF);
    check("R5", "pins 9..8 all high", rdata, 16'h8F03);
    // R7: scratch write keeps ports
    send(16'h1000 | 16'h003C, 10'h000);
    check("R7", "scratch write ports", {6'b0, pull_low}, 16'h03FF);
    send(16'h9000, 10'h000);
    check("R7", "scratch readback", rdata, 16'h903C);

    // R1: reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "pull_low after re-reset", {6'b0, pull_low}, 16'h0000);
    check("R1", "rdata after re-reset", rdata, 16'h0000);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule